// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast clock by a programmable ratio N = B·P + A and emits a one-cycle pulse once per N input cycles. It is meant as the feedback divider of a frequency synthesiser. Its dual-modulus prescaler divides by P+1 or by P and is built from a divide-by-4/5 core and a divide-by-P/4 extension. The main counter B counts prescaler cycles over the whole output period. The swallow counter A counts the prescaler cycles that still run at the larger modulus. After A of them the modulus drops to P for the rest of the period.

The settings are B, A and a prescaler code. Software writes them with a load strobe into a staging register, which the divider commits only at an output-period boundary. A period that is already running therefore always finishes with the settings it started with. Two flags describe the committed settings. One marks a configuration that is out of range. The other marks a ratio below the contiguity minimum P² − P.

A sequencer with three states controls the block. ST_IDLE is the state after reset: nothing is committed yet and the prescaler is held. The first load moves it to ST_SWALLOW if A is non-zero, or to ST_MAIN if A is zero. ST_SWALLOW runs the prescaler at P+1, and moves to ST_MAIN when the swallow counter reaches its last cycle. ST_MAIN runs at P. When the main counter reaches its last prescaler cycle, either state performs the period-end reload and enters ST_SWALLOW or ST_MAIN again, according to the newly committed A.

Top module: `swallow_fb_div`

## Requirements
- R1: When 3 ≤ B and A ≤ B, consecutive rising edges of div_out are exactly B·P + A input cycles apart. Each pulse is high for exactly one cycle.
- R2: Prescaler code 0 selects P = 8 (8/9), code 1 selects P = 16 (16/17) and code 2 selects P = 32 (32/33). Code 3 divides as P = 32 and raises cfg_bad.
- R3: With A = 0 the prescaler stays at modulus P for the whole period, so the spacing is B·P.
- R4: With A > B the spacing is B·(P+1) and cfg_bad is high. cfg_bad is also high when B < 3. A B value of 0 divides as if B were 1.
- R5: below_min is high exactly when the committed B·P + A is less than P·P − P.
- R6: Settings sampled on a clock edge with load high take effect at the first period boundary strictly after that edge. If several loads arrive in one period, the latest one wins. A period that is already running keeps its old settings.
- R7: After reset, div_out, cfg_bad and below_min are low, and no pulse appears until the first load. If that load is sampled at edge t, the first pulse is high in the cycle after edge t + N + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| sel_in | input | 2 | Prescaler code to be staged |
| b_in | input | 13 | Main counter value to be staged |
| a_in | input | 5 | Swallow counter value to be staged |
| load | input | 1 | Captures sel_in, b_in and a_in into the staging register |
| div_out | output | 1 | One-cycle pulse at each period boundary |
| cfg_bad | output | 1 | Committed settings are out of range (A > B, B < 3 or code 3) |
| below_min | output | 1 | Committed ratio is below P·P − P |

## Verification
The assertions check, on every cycle, the following:
- Each prescaler cycle lasts exactly P+1 input cycles in ST_SWALLOW and P in ST_MAIN.
- The committed settings change only on a commit.
- div_out is never high for two cycles in a row.
- ST_IDLE stays silent.
- ST_SWALLOW never runs with an empty swallow counter.

Only the bench scenarios can show the whole-period spacing for each code and the A = 0 and A > B cases. They also show the contiguity boundary at 55/56 against the flag, the deferral of loads to the next boundary, and which of several loads wins. The first-pulse latency after ST_IDLE is likewise shown only by the scenarios.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } seq_state_t;

    // prescaler modulus P selected by the 2-bit code; code 3 divides as 32
    function automatic logic [5:0] modulus_of(input logic [1:0] code);
        logic [5:0] p;
        unique case (code)
            2'd0:    p = 6'd8;
            2'd1:    p = 6'd16;
            default: p = 6'd32;
        endcase
        return p;
    endfunction

    // number of 4/5 core cycles making one prescaler cycle (P/4)
    function automatic logic [3:0] quarters_of(input logic [1:0] code);
        logic [5:0] p;
        p = modulus_of(code);
        return p[5:2];
    endfunction

endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
    import swdiv_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [1:0]     sel_in,
    input  logic [B_W-1:0] b_in,
    input  logic [A_W-1:0] a_in,
    input  logic           commit,
    input  logic           live,
    output logic           pend_v,
    output logic [B_W-1:0] nxt_b,
    output logic [A_W-1:0] nxt_a,
    output logic [B_W-1:0] act_b,
    output logic [A_W-1:0] act_a,
    output logic [1:0]     act_sel,
    output logic           cfg_bad,
    output logic           below_min
);
    localparam int N_W = B_W + 8;
    localparam logic [B_W-1:0] B_MIN = B_W'(3);

    logic [B_W-1:0] pend_b;
    logic [A_W-1:0] pend_a;
    logic [1:0]     pend_sel;

    // staging register: a strobe always wins over the clear caused by a commit
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_b   <= '0;
            pend_a   <= '0;
            pend_sel <= '0;
        end else if (load) begin
            pend_v   <= 1'b1;
            pend_b   <= b_in;
            pend_a   <= a_in;
            pend_sel <= sel_in;
        end else if (commit) begin
            pend_v   <= 1'b0;
        end
    end

    // committed settings used by the running period
    always_ff @(posedge clk) begin
        if (rst) begin
            act_b   <= '0;
            act_a   <= '0;
            act_sel <= '0;
        end else if (commit && pend_v) begin
            act_b   <= pend_b;
            act_a   <= pend_a;
            act_sel <= pend_sel;
        end
    end

    // values the counters reload with at a commit
    always_comb begin
        nxt_b = pend_v ? pend_b : act_b;
        nxt_a = pend_v ? pend_a : act_a;
    end

    logic [N_W-1:0] p_ext;
    logic [N_W-1:0] nominal;
    logic [N_W-1:0] floor_n;
    logic           a_over_b;

    always_comb begin
        p_ext    = N_W'(modulus_of(act_sel));
        nominal  = N_W'(act_b) * p_ext + N_W'(act_a);
        floor_n  = p_ext * p_ext - p_ext;
        a_over_b = B_W'(act_a) > act_b;
        cfg_bad  = live && ((act_sel == 2'd3) || a_over_b || (act_b < B_MIN));
        below_min = live && (nominal < floor_n);
    end

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       mod_plus,
    input  logic [1:0] sel,
    output logic       pre_tick
);
    // 4/5 core: counts 0..3, or 0..4 when stretched
    logic [2:0] core_q;
    // extension: counts core cycles within one prescaler cycle
    logic [3:0] ext_q;
    logic [3:0] ext_last;
    logic       stretch;
    logic       core_last;

    always_comb begin
        ext_last  = quarters_of(sel) - 4'd1;
        stretch   = mod_plus && (ext_q == 4'd0);
        core_last = stretch ? (core_q == 3'd4) : (core_q == 3'd3);
        pre_tick  = run && core_last && (ext_q == ext_last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            core_q <= '0;
            ext_q  <= '0;
        end else if (core_last) begin
            core_q <= '0;
            ext_q  <= (ext_q == ext_last) ? 4'd0 : ext_q + 4'd1;
        end else begin
            core_q <= core_q + 3'd1;
        end
    end

endmodule

// File: rtl/swdiv_seq.sv
module swdiv_seq
    import swdiv_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pend_v,
    input  logic [B_W-1:0] nxt_b,
    input  logic [A_W-1:0] nxt_a,
    input  logic           pre_tick,
    output seq_state_t     state,
    output logic           commit,
    output logic           live,
    output logic           mod_plus,
    output logic [B_W-1:0] b_cnt,
    output logic [A_W-1:0] a_cnt,
    output logic           div_out
);
    localparam logic [B_W-1:0] B_ONE = B_W'(1);
    localparam logic [A_W-1:0] A_ONE = A_W'(1);

    seq_state_t nxt_state;
    seq_state_t reload_state;
    logic       period_end;

    always_comb begin
        live         = (state != ST_IDLE);
        mod_plus     = (state == ST_SWALLOW);
        period_end   = live && pre_tick && (b_cnt <= B_ONE);
        commit       = ((state == ST_IDLE) && pend_v) || period_end;
        reload_state = (nxt_a != '0) ? ST_SWALLOW : ST_MAIN;
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (pend_v) nxt_state = reload_state;
            end
            ST_SWALLOW: begin
                if (period_end)
                    nxt_state = reload_state;
                else if (pre_tick && (a_cnt == A_ONE))
                    nxt_state = ST_MAIN;
            end
            ST_MAIN: begin
                if (period_end) nxt_state = reload_state;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt_state;
    end

    // swallow and main counters
    always_ff @(posedge clk) begin
        if (rst) begin
            b_cnt <= '0;
            a_cnt <= '0;
        end else if (commit) begin
            b_cnt <= nxt_b;
            a_cnt <= nxt_a;
        end else if (live && pre_tick) begin
            b_cnt <= b_cnt - B_ONE;
            if (state == ST_SWALLOW) a_cnt <= a_cnt - A_ONE;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) div_out <= 1'b0;
        else     div_out <= period_end;
    end

endmodule

// File: rtl/swallow_fb_div.sv
module swallow_fb_div
    import swdiv_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     sel_in,
    input  logic [B_W-1:0] b_in,
    input  logic [A_W-1:0] a_in,
    input  logic           load,
    output logic           div_out,
    output logic           cfg_bad,
    output logic           below_min
);
    logic           pend_v;
    logic [B_W-1:0] nxt_b;
    logic [A_W-1:0] nxt_a;
    logic [B_W-1:0] act_b;
    logic [A_W-1:0] act_a;
    logic [1:0]     act_sel;
    logic           commit;
    logic           live;
    logic           mod_plus;
    logic           pre_tick;
    logic [B_W-1:0] b_cnt;
    logic [A_W-1:0] a_cnt;
    seq_state_t     state;

    swdiv_cfg #(.B_W(B_W), .A_W(A_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .sel_in    (sel_in),
        .b_in      (b_in),
        .a_in      (a_in),
        .commit    (commit),
        .live      (live),
        .pend_v    (pend_v),
        .nxt_b     (nxt_b),
        .nxt_a     (nxt_a),
        .act_b     (act_b),
        .act_a     (act_a),
        .act_sel   (act_sel),
        .cfg_bad   (cfg_bad),
        .below_min (below_min)
    );

    swdiv_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (live),
        .mod_plus (mod_plus),
        .sel      (act_sel),
        .pre_tick (pre_tick)
    );

    swdiv_seq #(.B_W(B_W), .A_W(A_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pend_v   (pend_v),
        .nxt_b    (nxt_b),
        .nxt_a    (nxt_a),
        .pre_tick (pre_tick),
        .state    (state),
        .commit   (commit),
        .live     (live),
        .mod_plus (mod_plus),
        .b_cnt    (b_cnt),
        .a_cnt    (a_cnt),
        .div_out  (div_out)
    );

endmodule

// File: rtl/swallow_fb_div_chk.sv
module swallow_fb_div_chk
    import swdiv_pkg::*;
#(
    parameter int A_W = 5
) (
    input logic           clk,
    input logic           rst,
    input seq_state_t     state,
    input logic           pre_tick,
    input logic           mod_plus,
    input logic           commit,
    input logic [1:0]     act_sel,
    input logic [12:0]    act_b,
    input logic [A_W-1:0] act_a,
    input logic [A_W-1:0] a_cnt,
    input logic           div_out,
    input logic           cfg_bad,
    input logic           below_min
);
    // position inside the current prescaler cycle, starting at 1
    logic [6:0] gap_q;
    logic [6:0] want_len;

    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) gap_q <= 7'd1;
        else if (pre_tick)           gap_q <= 7'd1;
        else                         gap_q <= gap_q + 7'd1;
    end

    always_comb want_len = 7'(modulus_of(act_sel)) + (mod_plus ? 7'd1 : 7'd0);

    // R1
    prescale_len_chk: assert property (@(posedge clk) disable iff (rst)
        pre_tick |-> (gap_q == want_len));

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!div_out && !cfg_bad && !below_min));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(act_b) && $stable(act_a) && $stable(act_sel)));

    // R3
    swallow_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWALLOW) |-> (a_cnt != '0));

endmodule

bind swallow_fb_div swallow_fb_div_chk #(.A_W(A_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .pre_tick  (pre_tick),
    .mod_plus  (mod_plus),
    .commit    (commit),
    .act_sel   (act_sel),
    .act_b     (act_b),
    .act_a     (act_a),
    .a_cnt     (a_cnt),
    .div_out   (div_out),
    .cfg_bad   (cfg_bad),
    .below_min (below_min)
);

// File: tb/test_swallow_fb_div.sv
`timescale 1ns/1ps
module test_swallow_fb_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel_in = '0;
    logic [12:0] b_in = '0;
    logic [4:0]  a_in = '0;
    logic        load = 1'b0;
    logic        div_out;
    logic        cfg_bad;
    logic        below_min;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    swallow_fb_div i_swallow_fb_div (
        .clk       (clk),
        .rst       (rst),
        .sel_in    (sel_in),
        .b_in      (b_in),
        .a_in      (a_in),
        .load      (load),
        .div_out   (div_out),
        .cfg_bad   (cfg_bad),
        .below_min (below_min)
    );

    // ---------------- expected-value functions ----------------
    function automatic int p_of(input logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    function automatic int n_of(input int b, input int a, input logic [1:0] s);
        int p, be;
        p  = p_of(s);
        be = (b == 0) ? 1 : b;
        if (a > be) return be * (p + 1);
        return be * p + a;
    endfunction

    function automatic logic bad_of(input int b, input int a, input logic [1:0] s);
        return (s == 2'd3) || (a > b) || (b < 3);
    endfunction

    function automatic logic low_of(input int b, input int a, input logic [1:0] s);
        int p;
        p = p_of(s);
        return (b * p + a) < (p * p - p);
    endfunction

    // ---------------- behavioural reference ----------------
    bit         m_run = 0;
    bit         m_pv = 0;
    bit         m_pmid = 0;
    int         m_pb, m_pa, m_ab, m_aa;
    logic [1:0] m_ps, m_as;
    int         m_left = 0;
    bit         m_pulse = 0;
    string      m_tag = "R7";

    task automatic m_commit();
        m_ab = m_pb; m_aa = m_pa; m_as = m_ps; m_pv = 0;
        m_left = n_of(m_ab, m_aa, m_as);
        if (m_pmid)          m_tag = "R6";
        else if (m_aa == 0)  m_tag = "R3";
        else if (m_aa > m_ab) m_tag = "R4";
        else                 m_tag = "R1";
    endtask

    always @(posedge clk) begin
        m_pulse = 0;
        if (rst) begin
            m_run = 0; m_pv = 0; m_tag = "R7";
        end else begin
            if (!m_run) begin
                if (m_pv) begin m_commit(); m_run = 1; end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_pulse = 1;
                    if (m_pv) m_commit();
                    else m_left = n_of(m_ab, m_aa, m_as);
                end
            end
            if (load) begin
                m_pb = int'(b_in); m_pa = int'(a_in); m_ps = sel_in;
                m_pv = 1; m_pmid = m_run;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic eb, el;
        eb = m_run && bad_of(m_ab, m_aa, m_as);
        el = m_run && low_of(m_ab, m_aa, m_as);
        if (rst) begin
            check_bit("R7", "div_out in reset", div_out, 1'b0);
        end else begin
            check_bit(m_run ? m_tag : "R7", "div_out", div_out, m_pulse);
            check_bit((m_as == 2'd3) ? "R2" : "R4", "cfg_bad", cfg_bad, eb);
            check_bit("R5", "below_min", below_min, el);
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_load(input int b, input int a, input logic [1:0] s);
        @(negedge clk);
        b_in = 13'(b); a_in = 5'(a); sel_in = s; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int unsigned seed_r;
        seed_r = $urandom(32'd2024);
        // R7: reset and idle silence
        wait_cyc(5);
        @(negedge clk) rst = 1'b0;
        check_bit("R7", "cfg_bad after reset", cfg_bad, 1'b0);
        check_bit("R7", "below_min after reset", below_min, 1'b0);
        wait_cyc(30);
        // R1: basic ratio, P = 8, N = 42
        do_load(5, 2, 2'd0);
        wait_cyc(200);
        // R2: code 1 and code 2
        do_load(7, 3, 2'd1);
        wait_cyc(400);
        do_load(4, 9, 2'd2);
        wait_cyc(500);
        // R2: code 3 flagged
        do_load(5, 1, 2'd3);
        wait_cyc(500);
        // R3: A = 0
        do_load(6, 0, 2'd0);
        wait_cyc(200);
        // R4: A > B, and B below range
        do_load(3, 20, 2'd0);
        wait_cyc(200);
        do_load(2, 1, 2'd0);
        wait_cyc(100);
        do_load(0, 0, 2'd1);
        wait_cyc(100);
        // R5: contiguity boundary for P = 8 (54 below, 56 not)
        do_load(6, 6, 2'd0);
        wait_cyc(200);
        do_load(7, 0, 2'd0);
        wait_cyc(200);
        // R6: several loads within one period, the last one wins
        do_load(20, 5, 2'd2);
        wait_cyc(700);
        do_load(9, 1, 2'd0);
        wait_cyc(3);
        do_load(11, 4, 2'd1);
        wait_cyc(2000);
        // randomized settings and load phases
        for (int i = 0; i < 60; i++) begin
            int b, a;
            logic [1:0] s;
            s = 2'($urandom % 4);
            b = ($urandom % 8 == 0) ? int'($urandom % 3) : 3 + int'($urandom % 18);
            a = int'($urandom % 32);
            do_load(b, a, s);
            wait_cyc(int'($urandom % 1200));
        end
        wait_cyc(1500);
        // R7: reset again returns to silence
        @(negedge clk) rst = 1'b1;
        wait_cyc(3);
        @(negedge clk) rst = 1'b0;
        wait_cyc(100);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule